// File: doc/BRIEF.md
# Next-PC Branch and Jump Selector

This block decides where a single-cycle processor fetches next. It takes the word address of the already incremented program counter, the 16-bit branch displacement and 26-bit jump field from the instruction, the three flow-control bits from the main decoder and the zero flag from the ALU compare. It returns the next word address and a one-bit select that says whether a target replaced the sequential address.

All addresses are word addresses: the two low byte-address bits are always zero and are never carried. A branch target is the incremented word address plus the sign-extended displacement, which wraps modulo the address width. A jump target keeps the top region bits of the incremented address and fills the rest from the jump field. The block is purely combinational; the PC register that closes the loop sits outside it.

Top module: `nxtpc_select`

## Requirements
- R1: With is_jump, is_beq and is_bne all 0, take_target is 0 and next_word equals inc_word, whatever alu_zero and the immediates hold.
- R2: With is_beq = 1 and alu_zero = 1, take_target is 1 and next_word = inc_word + br_imm sign-extended to 30 bits.
- R3: With is_beq = 1 and alu_zero = 0, take_target is 0 and next_word equals inc_word.
- R4: With is_bne = 1, the branch is taken (take_target 1, next_word = branch target) when alu_zero = 0 and not taken (take_target 0, next_word = inc_word) when alu_zero = 1.
- R5: With is_jump = 1, take_target is 1 and next_word = {inc_word[29:26], jmp_imm[25:0]} for either value of alu_zero.
- R6: A displacement with bit 15 set is negative: the target lies below inc_word by 65536 minus the displacement value.
- R7: Branch arithmetic wraps modulo 2^30 in both directions with no overflow indication.
- R8: jmp_imm has no effect on next_word during a branch, and br_imm has no effect on next_word during a jump.
- R9: Fed back through a PC register (inc_word = PC + 1 each cycle), the byte address {next_word, 2'b00} follows a mixed run of taken branches, untaken branches and jumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inc_word | input | 30 | Word address of the incremented PC |
| br_imm | input | 16 | Signed branch displacement in words |
| jmp_imm | input | 26 | Jump word-address field |
| is_beq | input | 1 | Branch if compare was equal |
| is_bne | input | 1 | Branch if compare was not equal |
| is_jump | input | 1 | Unconditional jump |
| alu_zero | input | 1 | Zero flag of the ALU compare |
| next_word | output | 30 | Next PC word address |
| take_target | output | 1 | 1 when a branch or jump target is selected |

## Verification
Each control bit is driven alone against both values of alu_zero, which separates a correct taken/not-taken decision from one that ignores the flag or inverts it for one branch type. Positive, negative and wrapping displacements tell a true sign extension and modulo add from a zero extension or a truncated sum. Jumps are run with distinct region bits and with junk in the unused immediate, so a spliced target built from the wrong bits or the wrong field shows. A closed loop with a PC register in the bench checks the byte-address sequence over several consecutive decisions.

// File: rtl/nxtpc_pkg.sv
package nxtpc_pkg;
    typedef struct packed {
        logic jump;
        logic beq;
        logic bne;
    } flow_ctl_t;
endpackage

// File: rtl/nxtpc_branch_add.sv
module nxtpc_branch_add #(
    parameter int ADDR_W = 30,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] base_word,
    input  logic [IMM_W-1:0]  disp,
    output logic [ADDR_W-1:0] target_word
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_ext = {{EXT_W{disp[IMM_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[ADDR_W-1:0];
        end
    endgenerate

    // Sum wraps modulo 2^ADDR_W by width truncation.
    assign target_word = base_word + disp_ext;
endmodule

// File: rtl/nxtpc_jump_splice.sv
module nxtpc_jump_splice #(
    parameter int ADDR_W = 30,
    parameter int JIMM_W = 26
) (
    input  logic [ADDR_W-1:0] base_word,
    input  logic [JIMM_W-1:0] field,
    output logic [ADDR_W-1:0] target_word
);
    localparam int REGION_W = ADDR_W - JIMM_W;

    generate
        if (REGION_W > 0) begin : g_region
            assign target_word = {base_word[ADDR_W-1:JIMM_W], field};
        end else begin : g_flat
            assign target_word = field[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/nxtpc_decide.sv
module nxtpc_decide
    import nxtpc_pkg::*;
(
    input  flow_ctl_t ctl,
    input  logic      zero,
    output logic      take,
    output logic      pick_jump
);
    always_comb begin
        pick_jump = ctl.jump;
        take      = ctl.jump | (ctl.beq & zero) | (ctl.bne & ~zero);
    end
endmodule

// File: rtl/nxtpc_select.sv
module nxtpc_select
    import nxtpc_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int IMM_W  = 16,
    parameter int JIMM_W = 26
) (
    input  logic [ADDR_W-1:0] inc_word,
    input  logic [IMM_W-1:0]  br_imm,
    input  logic [JIMM_W-1:0] jmp_imm,
    input  logic              is_beq,
    input  logic              is_bne,
    input  logic              is_jump,
    input  logic              alu_zero,
    output logic [ADDR_W-1:0] next_word,
    output logic              take_target
);
    localparam int REGION_W = ADDR_W - JIMM_W;

    typedef struct packed {
        logic [ADDR_W-1:0] word;
        logic              take;
    } sel_t;

    flow_ctl_t         ctl;
    logic [ADDR_W-1:0] br_word;
    logic [ADDR_W-1:0] jp_word;
    logic              take_w;
    logic              jump_w;
    sel_t              sel_d;

    assign ctl = '{jump: is_jump, beq: is_beq, bne: is_bne};

    nxtpc_branch_add #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_badd (
        .base_word  (inc_word),
        .disp       (br_imm),
        .target_word(br_word)
    );

    nxtpc_jump_splice #(.ADDR_W(ADDR_W), .JIMM_W(JIMM_W)) u_jsp (
        .base_word  (inc_word),
        .field      (jmp_imm),
        .target_word(jp_word)
    );

    nxtpc_decide u_dec (
        .ctl      (ctl),
        .zero     (alu_zero),
        .take     (take_w),
        .pick_jump(jump_w)
    );

    always_comb begin
        sel_d.take = take_w;
        if (!take_w)     sel_d.word = inc_word;
        else if (jump_w) sel_d.word = jp_word;
        else             sel_d.word = br_word;
    end

    assign next_word   = sel_d.word;
    assign take_target = sel_d.take;

    // Checks across the decision, adder and splice submodules.
    always_comb begin
        if (!$isunknown({inc_word, br_imm, jmp_imm, is_beq, is_bne, is_jump, alu_zero})) begin
            a_r5_jump_forces_take: assert (!is_jump || take_target)
                else $error("jump did not select a target");
            a_r1_sequential_hold: assert (take_target || next_word == inc_word)
                else $error("untaken path altered the address");
            a_r5_jump_region_kept: assert (!is_jump ||
                    (next_word[ADDR_W-1 -: REGION_W] == inc_word[ADDR_W-1 -: REGION_W]
                     && next_word[JIMM_W-1:0] == jmp_imm))
                else $error("jump target splice wrong");
            a_r2_branch_distance: assert (!(take_target && !is_jump) ||
                    ($signed(next_word - inc_word) == $signed({{(ADDR_W-IMM_W){br_imm[IMM_W-1]}}, br_imm})))
                else $error("branch target distance wrong");
            a_r4_bne_needs_nonzero: assert (!(is_bne && !is_jump && !is_beq && alu_zero) || !take_target)
                else $error("bne taken on equal compare");
        end
    end
endmodule

// File: tb/nxtpc_select_test.sv
module nxtpc_select_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] inc_word;
    logic [15:0] br_imm;
    logic [25:0] jmp_imm;
    logic        is_beq, is_bne, is_jump, alu_zero;
    logic [29:0] next_word;
    logic        take_target;
    logic        loop_mode = 1'b0;
    logic [29:0] pc_q;
    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    nxtpc_select uut (
        .inc_word(inc_word), .br_imm(br_imm), .jmp_imm(jmp_imm),
        .is_beq(is_beq), .is_bne(is_bne), .is_jump(is_jump), .alu_zero(alu_zero),
        .next_word(next_word), .take_target(take_target)
    );

    // PC register closing the loop for the R9 sequence.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= 30'h0000_0100;
        else        pc_q <= next_word;
    end

    always_comb if (loop_mode) inc_word = pc_q + 30'd1;

    // Expected values from byte-address arithmetic.
    function automatic logic [29:0] exp_branch(input logic [29:0] inc, input logic [15:0] d);
        logic [31:0] b;
        b = {inc, 2'b00} + ({{16{d[15]}}, d} << 2);
        return b[31:2];
    endfunction

    function automatic logic [29:0] exp_jump(input logic [29:0] inc, input logic [25:0] f);
        logic [31:0] b;
        b = {inc, 2'b00};
        b = {b[31:28], f, 2'b00};
        return b[31:2];
    endfunction

    task automatic check(input string req, input logic [29:0] exp_w, input logic exp_t);
        checks++;
        if (next_word !== exp_w || take_target !== exp_t) begin
            fails++;
            $display("FAIL %s: next=%h take=%b expected next=%h take=%b",
                     req, next_word, take_target, exp_w, exp_t);
        end
    endtask

    task automatic drive(input logic [29:0] inc, input logic [15:0] d, input logic [25:0] f,
                         input logic j, input logic bq, input logic bn, input logic z);
        if (!loop_mode) inc_word = inc;
        br_imm = d; jmp_imm = f; is_jump = j; is_beq = bq; is_bne = bn; alu_zero = z;
        #1;
    endtask

    task automatic t_r1_idle();
        drive(30'h0000_1234, 16'hFFFF, 26'h3FF_FFFF, 0, 0, 0, 1);
        check("R1", 30'h0000_1234, 1'b0);
        drive(30'h2000_0001, 16'h0040, 26'h000_0001, 0, 0, 0, 0);
        check("R1", 30'h2000_0001, 1'b0);
    endtask

    task automatic t_r2_r3_beq();
        drive(30'h0000_1000, 16'h0010, 26'h155_5555, 0, 1, 0, 1);
        check("R2", exp_branch(30'h0000_1000, 16'h0010), 1'b1);
        drive(30'h0000_1000, 16'h0010, 26'h155_5555, 0, 1, 0, 0);
        check("R3", 30'h0000_1000, 1'b0);
    endtask

    task automatic t_r4_bne();
        drive(30'h0000_0800, 16'h0123, 26'h0, 0, 0, 1, 0);
        check("R4", exp_branch(30'h0000_0800, 16'h0123), 1'b1);
        drive(30'h0000_0800, 16'h0123, 26'h0, 0, 0, 1, 1);
        check("R4", 30'h0000_0800, 1'b0);
    endtask

    task automatic t_r5_jump();
        drive(30'h2ABC_DEF0, 16'h8000, 26'h123_4567, 1, 0, 0, 0);
        check("R5", exp_jump(30'h2ABC_DEF0, 26'h123_4567), 1'b1);
        drive(30'h0400_0000, 16'h0001, 26'h3FF_FFF0, 1, 0, 0, 1);
        check("R5", exp_jump(30'h0400_0000, 26'h3FF_FFF0), 1'b1);
    endtask

    task automatic t_r6_negative();
        drive(30'h0000_1000, 16'hFFF8, 26'h0, 0, 1, 0, 1);
        check("R6", 30'h0000_0FF8, 1'b1);
        drive(30'h0002_0000, 16'h8000, 26'h0, 0, 0, 1, 0);
        check("R6", 30'h0001_8000, 1'b1);
    endtask

    task automatic t_r7_wrap();
        drive(30'h3FFF_FFF0, 16'h0020, 26'h0, 0, 1, 0, 1);
        check("R7", 30'h0000_0010, 1'b1);
        drive(30'h0000_0005, 16'hFFF8, 26'h0, 0, 0, 1, 0);
        check("R7", 30'h3FFF_FFFD, 1'b1);
    endtask

    task automatic t_r8_unused_field();
        drive(30'h0000_2000, 16'h0004, 26'h000_0000, 0, 1, 0, 1);
        check("R8", 30'h0000_2004, 1'b1);
        drive(30'h0000_2000, 16'h0004, 26'h3FF_FFFF, 0, 1, 0, 1);
        check("R8", 30'h0000_2004, 1'b1);
        drive(30'h1000_0000, 16'h7FFF, 26'h000_0040, 1, 0, 0, 0);
        check("R8", 30'h1000_0040, 1'b1);
    endtask

    task automatic step_r9(input logic [15:0] d, input logic [25:0] f,
                           input logic j, input logic bq, input logic bn, input logic z,
                           input logic [31:0] exp_byte);
        @(negedge clk);
        drive(30'h0, d, f, j, bq, bn, z);
        @(posedge clk); #1;
        checks++;
        if ({pc_q, 2'b00} !== exp_byte) begin
            fails++;
            $display("FAIL R9: pc=%h expected %h", {pc_q, 2'b00}, exp_byte);
        end
    endtask

    task automatic t_r9_loop();
        loop_mode = 1'b1;
        drive(30'h0, 16'h0, 26'h0, 0, 0, 0, 0);
        rst_n = 1'b0; #3; rst_n = 1'b1;
        checks++;
        if ({pc_q, 2'b00} !== 32'h0000_0400) begin
            fails++;
            $display("FAIL R9: reset pc=%h expected 00000400", {pc_q, 2'b00});
        end
        step_r9(16'h0, 26'h0, 0, 0, 0, 0, 32'h0000_0404);          // sequential
        step_r9(16'h0003, 26'h0, 0, 1, 0, 1, 32'h0000_0414);       // beq taken
        step_r9(16'h0003, 26'h0, 0, 1, 0, 0, 32'h0000_0418);       // beq not taken
        step_r9(16'hFFFC, 26'h0, 0, 0, 1, 0, 32'h0000_040C);       // bne back
        step_r9(16'h0, 26'h000_2000, 1, 0, 0, 1, 32'h0000_8000);   // jump
        step_r9(16'h0010, 26'h0, 0, 0, 1, 1, 32'h0000_8004);       // bne not taken
        loop_mode = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        drive(30'h0, 16'h0, 26'h0, 0, 0, 0, 0);
        #3; rst_n = 1'b1;
        t_r1_idle();
        t_r2_r3_beq();
        t_r4_bne();
        t_r5_jump();
        t_r6_negative();
        t_r7_wrap();
        t_r8_unused_field();
        t_r9_loop();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule